// File: doc/BRIEF.md
# Two-Dimensional DMA Word Address Sequencer

This block produces the word addresses for one channel of a two-dimensional DMA engine. A start pulse captures a word base address, a line length in words, a line stride in words and a line count minus one. The sequencer then presents one 32-bit-word address per beat and advances only when the beat is accepted. In the default mode it walks the programmed number of lines, each beginning one stride after the previous one. It raises a single completion pulse and goes idle. The current address is always visible on `cur_addr`, so software can work out how much of the transfer remains.

A line length of zero selects ring mode. In this mode the address climbs through a region of stride × (line count + 1) words and jumps back to the base at the end of the region, with no end. The region is treated as two equal halves. One pulse marks the end of the first half and another marks the end of the whole region. A loop-enable input freezes the ring sequence in place while low and lets it continue from the same point when raised again. A stop input sends the sequencer back to idle at any time.

Top module: `dma2d_addr_gen`

## Requirements
- R1: While reset is held and after it is released: `busy`, `beat_valid`, `ring_mode` and all three pulse outputs are 0, and `cur_addr` is 0.
- R2: With a nonzero line length W, stride S, line count field N and base B, the accepted beats carry the addresses B + l·S + w, for l = 0..N and w = 0..W−1, in that order.
- R3: `cur_addr` changes only on a clock edge with `beat_valid` and `beat_ready` both high. Back-pressure holds it steady.
- R4: In line mode, `done_pulse` is high for exactly the one cycle after the edge that accepts the final beat. `busy` is low from that same cycle, and `cur_addr` then reads the final address plus one.
- R5: A line length of 0 selects ring mode (`ring_mode` = 1). Beat k carries B + (k mod S·(N+1)), and the sequence never ends by itself.
- R6: In ring mode with region size R ≥ 2, `half_irq` is high for the one cycle after acceptance of the beat at offset R/2 − 1. `full_irq` is high for the one cycle after acceptance of the beat at offset R − 1. Neither pulse occurs in the same cycle as any other pulse.
- R7: In ring mode, `loop_en` low forces `beat_valid` low and freezes `cur_addr`. Raising it resumes at the frozen address. In line mode `loop_en` has no effect.
- R8: `stop` forces `beat_valid` low at once. From the next cycle `busy` is low and `cur_addr` is held, with no pulse raised. `stop` wins over a simultaneous `start`.
- R9: A `start` pulse while `busy` is high is ignored, and the running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture the configuration and begin (idle only) |
| stop | input | 1 | Abort and return to idle |
| loop_en | input | 1 | Ring-mode run enable; low pauses |
| cfg_base | input | ADDR_W | Word base address |
| cfg_line_words | input | LEN_W | Words per line; 0 selects ring mode |
| cfg_stride | input | LEN_W | Words between line starts |
| cfg_lines_m1 | input | LEN_W | Number of lines minus one |
| beat_ready | input | 1 | Downstream accepts the current beat |
| beat_valid | output | 1 | A beat address is offered |
| cur_addr | output | ADDR_W | Live word address of the next beat |
| busy | output | 1 | Sequence in progress |
| ring_mode | output | 1 | Active sequence is in ring mode |
| done_pulse | output | 1 | Line-mode transfer finished |
| half_irq | output | 1 | Ring first half completed |
| full_irq | output | 1 | Ring region completed |

## Verification
After an accepting edge, the address advances at that same edge. The done, half and full pulses appear one cycle later, and `busy` falls the edge after `stop`. A start pulse makes `beat_valid` visible the cycle after its edge. The bench drives inputs just after the rising edge and samples every output at the falling edge. A beat seen with valid and ready at a falling edge is compared with the head of the expected queue. The pulse expected for that beat is checked at the next falling edge, and any pulse at any other falling edge is reported. Each stall seen at a falling edge is followed by a check that the address is unchanged one falling edge later.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

    localparam int unsigned ADDR_W_DEF = 32;
    localparam int unsigned LEN_W_DEF  = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LINES = 2'd1,
        ST_RING  = 2'd2
    } gen_state_e;

    typedef struct packed {
        logic done;
        logic half;
        logic full;
    } gen_evt_t;

    // words in a ring region: stride * (lines + 1)
    function automatic logic [63:0] region_words(input logic [63:0] stride,
                                                 input logic [63:0] lines_m1);
        return stride * (lines_m1 + 64'd1);
    endfunction

endpackage

// File: rtl/dma2d_line_walker.sv
module dma2d_line_walker #(
    parameter int unsigned ADDR_W = dma2d_pkg::ADDR_W_DEF,
    parameter int unsigned LEN_W  = dma2d_pkg::LEN_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              adv,
    input  logic [ADDR_W-1:0] ld_base,
    input  logic [LEN_W-1:0]  ld_words,
    input  logic [LEN_W-1:0]  ld_stride,
    input  logic [LEN_W-1:0]  ld_lines_m1,
    input  logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] next_addr,
    output logic              last_beat
);
    logic [ADDR_W-1:0] line_start;
    logic [LEN_W-1:0]  word_idx;
    logic [LEN_W-1:0]  line_idx;
    logic [LEN_W-1:0]  words_q;
    logic [LEN_W-1:0]  stride_q;
    logic [LEN_W-1:0]  lines_q;
    logic              end_of_line;

    assign end_of_line = (word_idx == words_q - 1'b1);
    assign last_beat   = end_of_line && (line_idx == lines_q);

    always_comb begin
        if (end_of_line && !last_beat)
            next_addr = line_start + ADDR_W'(stride_q);
        else
            next_addr = cur_addr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_start <= '0;
            word_idx   <= '0;
            line_idx   <= '0;
            words_q    <= '0;
            stride_q   <= '0;
            lines_q    <= '0;
        end else if (load) begin
            line_start <= ld_base;
            word_idx   <= '0;
            line_idx   <= '0;
            words_q    <= ld_words;
            stride_q   <= ld_stride;
            lines_q    <= ld_lines_m1;
        end else if (adv) begin
            if (end_of_line) begin
                word_idx   <= '0;
                line_idx   <= line_idx + 1'b1;
                line_start <= line_start + ADDR_W'(stride_q);
            end else begin
                word_idx   <= word_idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/dma2d_ring_walker.sv
module dma2d_ring_walker #(
    parameter int unsigned ADDR_W = dma2d_pkg::ADDR_W_DEF,
    parameter int unsigned LEN_W  = dma2d_pkg::LEN_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              adv,
    input  logic [ADDR_W-1:0] ld_base,
    input  logic [LEN_W-1:0]  ld_stride,
    input  logic [LEN_W-1:0]  ld_lines_m1,
    input  logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] next_addr,
    output logic              at_half,
    output logic              at_end
);
    localparam int unsigned POS_W = 2 * LEN_W;

    logic [ADDR_W-1:0] base_q;
    logic [POS_W-1:0]  pos;
    logic [POS_W-1:0]  region_q;
    logic [POS_W-1:0]  half_q;
    logic [POS_W-1:0]  region_ld;

    assign region_ld = POS_W'(dma2d_pkg::region_words(64'(ld_stride), 64'(ld_lines_m1)));

    assign at_end    = (region_q != '0) && (pos == region_q - 1'b1);
    assign at_half   = (half_q != '0) && (pos == half_q - 1'b1);
    assign next_addr = at_end ? base_q : cur_addr + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= '0;
            pos      <= '0;
            region_q <= '0;
            half_q   <= '0;
        end else if (load) begin
            base_q   <= ld_base;
            pos      <= '0;
            region_q <= region_ld;
            half_q   <= region_ld >> 1;
        end else if (adv) begin
            pos <= at_end ? '0 : pos + 1'b1;
        end
    end
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen #(
    parameter int unsigned ADDR_W = dma2d_pkg::ADDR_W_DEF,
    parameter int unsigned LEN_W  = dma2d_pkg::LEN_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stop,
    input  logic              loop_en,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [LEN_W-1:0]  cfg_line_words,
    input  logic [LEN_W-1:0]  cfg_stride,
    input  logic [LEN_W-1:0]  cfg_lines_m1,
    input  logic              beat_ready,
    output logic              beat_valid,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              busy,
    output logic              ring_mode,
    output logic              done_pulse,
    output logic              half_irq,
    output logic              full_irq
);
    import dma2d_pkg::*;

    gen_state_e        state;
    gen_evt_t          evt_q;
    logic [ADDR_W-1:0] addr_q;
    logic              launch;
    logic              accept;
    logic [ADDR_W-1:0] line_next;
    logic [ADDR_W-1:0] ring_next;
    logic              line_last;
    logic              ring_half;
    logic              ring_end;

    assign launch     = start && !stop && (state == ST_IDLE);
    assign beat_valid = !stop && ((state == ST_LINES) || ((state == ST_RING) && loop_en));
    assign accept     = beat_valid && beat_ready;

    dma2d_line_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) line_i (
        .clk        (clk),
        .rst        (rst),
        .load       (launch),
        .adv        (accept && (state == ST_LINES)),
        .ld_base    (cfg_base),
        .ld_words   (cfg_line_words),
        .ld_stride  (cfg_stride),
        .ld_lines_m1(cfg_lines_m1),
        .cur_addr   (addr_q),
        .next_addr  (line_next),
        .last_beat  (line_last)
    );

    dma2d_ring_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) ring_i (
        .clk        (clk),
        .rst        (rst),
        .load       (launch),
        .adv        (accept && (state == ST_RING)),
        .ld_base    (cfg_base),
        .ld_stride  (cfg_stride),
        .ld_lines_m1(cfg_lines_m1),
        .cur_addr   (addr_q),
        .next_addr  (ring_next),
        .at_half    (ring_half),
        .at_end     (ring_end)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            addr_q <= '0;
            evt_q  <= '0;
        end else begin
            evt_q <= '0;
            if (stop) begin
                state <= ST_IDLE;
            end else if (launch) begin
                addr_q <= cfg_base;
                state  <= (cfg_line_words == '0) ? ST_RING : ST_LINES;
            end else if (accept) begin
                if (state == ST_RING) begin
                    addr_q     <= ring_next;
                    evt_q.half <= ring_half;
                    evt_q.full <= ring_end;
                end else begin
                    addr_q <= line_next;
                    if (line_last) begin
                        state      <= ST_IDLE;
                        evt_q.done <= 1'b1;
                    end
                end
            end
        end
    end

    assign cur_addr   = addr_q;
    assign busy       = (state != ST_IDLE);
    assign ring_mode  = (state == ST_RING);
    assign done_pulse = evt_q.done;
    assign half_irq   = evt_q.half;
    assign full_irq   = evt_q.full;
endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk #(
    parameter int unsigned ADDR_W = dma2d_pkg::ADDR_W_DEF
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              stop,
    input logic              loop_en,
    input logic              beat_ready,
    input logic              beat_valid,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              busy,
    input logic              ring_mode,
    input logic              done_pulse,
    input logic              half_irq,
    input logic              full_irq
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> (!busy && !beat_valid && !done_pulse));

    // R3
    hold_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !beat_ready && !stop) |=> $stable(cur_addr));

    // R4
    done_after_beat_chk: assert property (@(posedge clk) disable iff (rst)
        done_pulse |-> ($past(beat_valid && beat_ready && !ring_mode) && !busy));

    // R6
    pulse_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done_pulse, half_irq, full_irq}));

    // R6
    ring_pulse_src_chk: assert property (@(posedge clk) disable iff (rst)
        (half_irq || full_irq) |-> $past(ring_mode && beat_valid && beat_ready));

    // R7
    pause_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && ring_mode && !loop_en && !stop) |=> $stable(cur_addr));

    // R8
    stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
        stop |=> (!busy && !done_pulse && !half_irq && !full_irq));

    // R8
    valid_busy_chk: assert property (@(posedge clk) disable iff (rst)
        beat_valid |-> (busy && !stop));

    // R9
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (start && busy && !stop && !beat_ready) |=> (busy && $stable(cur_addr)));
endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/dma2d_addr_gen_tb.sv
`timescale 1ns/1ps
module dma2d_addr_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        stop = 1'b0;
    logic        loop_en = 1'b1;
    logic [31:0] cfg_base = '0;
    logic [15:0] cfg_line_words = '0;
    logic [15:0] cfg_stride = '0;
    logic [15:0] cfg_lines_m1 = '0;
    logic        ready_man = 1'b1;
    logic        bp_mode = 1'b0;
    logic [7:0]  lfsr = 8'hA5;
    logic        beat_ready;
    logic        beat_valid;
    logic [31:0] cur_addr;
    logic        busy, ring_mode, done_pulse, half_irq, full_irq;

    int total = 0;
    int bad = 0;
    logic [31:0] exp_a[$];
    int          exp_e[$];
    int          due = 0;
    logic        hold_pend = 1'b0;
    logic [31:0] held = '0;
    logic [31:0] pa;
    int          pe;

    always #4 clk = ~clk;

    assign beat_ready = bp_mode ? lfsr[0] : ready_man;

    always @(posedge clk) begin
        #1;
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end

    dma2d_addr_gen dut_i (
        .clk(clk), .rst(rst), .start(start), .stop(stop), .loop_en(loop_en),
        .cfg_base(cfg_base), .cfg_line_words(cfg_line_words),
        .cfg_stride(cfg_stride), .cfg_lines_m1(cfg_lines_m1),
        .beat_ready(beat_ready), .beat_valid(beat_valid), .cur_addr(cur_addr),
        .busy(busy), .ring_mode(ring_mode), .done_pulse(done_pulse),
        .half_irq(half_irq), .full_irq(full_irq)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
        end
    endtask

    // evt codes: 0 none, 1 done, 2 half, 3 full
    function automatic logic [2:0] evt_vec(input int e);
        case (e)
            1: return 3'b100;
            2: return 3'b010;
            3: return 3'b001;
            default: return 3'b000;
        endcase
    endfunction

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (due != 0 || done_pulse || half_irq || full_irq)
                check({done_pulse, half_irq, full_irq} == evt_vec(due),
                      (due == 1) ? "R4 done pulse" : (due != 0) ? "R6 ring pulse" : "R8 stray pulse",
                      {29'd0, done_pulse, half_irq, full_irq}, {29'd0, evt_vec(due)});
            due = 0;
            if (hold_pend)
                check(cur_addr == held, "R3 address held under back-pressure", cur_addr, held);
            hold_pend = 1'b0;
            if (beat_valid && beat_ready) begin
                if (exp_a.size() == 0) begin
                    check(1'b0, "R2 unexpected beat", cur_addr, 32'hFFFF_FFFF);
                end else begin
                    pa = exp_a.pop_front();
                    pe = exp_e.pop_front();
                    check(cur_addr == pa, ring_mode ? "R5 ring address" : "R2 line address", cur_addr, pa);
                    due = pe;
                end
            end else if (beat_valid && !stop) begin
                hold_pend = 1'b1;
                held = cur_addr;
            end
        end
    end

    task automatic push(input logic [31:0] a, input int e);
        exp_a.push_back(a);
        exp_e.push_back(e);
    endtask

    task automatic go(input logic [31:0] b, input logic [15:0] w, input logic [15:0] s, input logic [15:0] n);
        @(posedge clk); #1;
        cfg_base = b; cfg_line_words = w; cfg_stride = s; cfg_lines_m1 = n; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic wait_empty();
        wait (exp_a.size() == 0);
        @(posedge clk); #1;
    endtask

    task automatic push_lines(input logic [31:0] b, input int w, input int s, input int n, input int limit);
        int cnt = 0;
        for (int l = 0; l <= n; l++)
            for (int k = 0; k < w; k++) begin
                if (cnt < limit)
                    push(b + l * s + k, (l == n && k == w - 1) ? 1 : 0);
                cnt++;
            end
    endtask

    task automatic push_ring(input logic [31:0] b, input int region, input int from, input int count);
        for (int k = from; k < from + count; k++) begin
            int off = k % region;
            push(b + off, (off == region / 2 - 1) ? 2 : (off == region - 1) ? 3 : 0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!busy && !beat_valid && !ring_mode, "R1 idle during reset", {29'd0, busy, beat_valid, ring_mode}, 0);
        #1 rst = 1'b0;
        @(negedge clk);
        check(!busy && !beat_valid && !done_pulse && !half_irq && !full_irq, "R1 idle after reset",
              {27'd0, busy, beat_valid, done_pulse, half_irq, full_irq}, 0);
        check(cur_addr == 0, "R1 address after reset", cur_addr, 0);

        // line mode, strided, with a start while busy (R9)
        push_lines(32'h100, 3, 5, 2, 99);
        go(32'h100, 16'd3, 16'd5, 16'd2);
        repeat (2) @(posedge clk);
        #1;
        cfg_base = 32'h9000; cfg_line_words = 16'd0; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        wait_empty();
        @(negedge clk);
        check(!busy && !ring_mode, "R9 running transfer unchanged by start while busy", {31'd0, busy}, 0);
        check(cur_addr == 32'h10D, "R4 address after completion", cur_addr, 32'h10D);

        // line mode, contiguous, back-pressure, loop_en low ignored (R7)
        loop_en = 1'b0;
        bp_mode = 1'b1;
        push_lines(32'h3000, 1, 1, 5, 99);
        go(32'h3000, 16'd1, 16'd1, 16'd5);
        wait_empty();
        bp_mode = 1'b0;
        @(negedge clk);
        check(!busy, "R7 loop_en low ignored in line mode", {31'd0, busy}, 0);
        check(cur_addr == 32'h3006, "R4 address after completion", cur_addr, 32'h3006);

        // ring mode: region 8, half at 4
        loop_en = 1'b1;
        push_ring(32'h200, 8, 0, 20);
        go(32'h200, 16'd0, 16'd4, 16'd1);
        wait_empty();
        loop_en = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check(!beat_valid && busy && ring_mode, "R7 paused ring offers no beat",
                  {29'd0, beat_valid, busy, ring_mode}, 32'd3);
            check(cur_addr == 32'h204, "R7 paused ring address frozen", cur_addr, 32'h204);
        end
        @(posedge clk); #1;
        push_ring(32'h200, 8, 20, 6);
        loop_en = 1'b1;
        wait_empty();
        stop = 1'b1; ready_man = 1'b0;
        @(posedge clk); #1;
        stop = 1'b0;
        @(negedge clk);
        check(!busy && !beat_valid, "R8 idle after stop in ring", {30'd0, busy, beat_valid}, 0);
        check(cur_addr == 32'h202, "R8 address held by stop", cur_addr, 32'h202);

        // stop mid line transfer: no done pulse
        ready_man = 1'b1;
        push_lines(32'h4000, 2, 8, 2, 4);
        go(32'h4000, 16'd2, 16'd8, 16'd2);
        wait_empty();
        stop = 1'b1; ready_man = 1'b0;
        @(posedge clk); #1;
        stop = 1'b0;
        repeat (3) @(negedge clk);
        check(!busy, "R8 idle after stop in line mode", {31'd0, busy}, 0);
        check(cur_addr == 32'h4010, "R8 address held by stop", cur_addr, 32'h4010);

        // stop beats a simultaneous start
        @(posedge clk); #1;
        cfg_base = 32'h7777; cfg_line_words = 16'd2; stop = 1'b1; start = 1'b1;
        @(posedge clk); #1;
        stop = 1'b0; start = 1'b0;
        @(negedge clk);
        check(!busy && cur_addr == 32'h4010, "R8 stop wins over start", cur_addr, 32'h4010);

        // ring mode under back-pressure: region 12, half at 6
        ready_man = 1'b1;
        bp_mode = 1'b1;
        push_ring(32'h50, 12, 0, 30);
        go(32'h50, 16'd0, 16'd3, 16'd3);
        @(negedge clk);
        check(ring_mode && busy, "R5 zero line length selects ring", {30'd0, ring_mode, busy}, 3);
        wait_empty();
        stop = 1'b1; bp_mode = 1'b0; ready_man = 1'b0;
        @(posedge clk); #1;
        stop = 1'b0;
        repeat (3) @(negedge clk);
        check(!busy && cur_addr == 32'h56, "R5 ring position after 30 beats", cur_addr, 32'h56);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired, R2 sequence hung");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule